// File: doc/BRIEF.md
# Farm-Highway Traffic Light Controller

This block drives the signal heads at a crossing between a busy highway and a quiet farm road. The highway keeps a green light by default. The farm road gets a green light only when a car sensor on that road reports a waiting vehicle and the highway has already had a minimum green period. The farm green ends as soon as the farm road is empty, or when a maximum period has run out. Each green is followed by a yellow phase of fixed length.

The controller has two cooperating parts. A four-phase sequencer decides which road is served. A restartable interval counter supplies a short-interval flag and a long-interval flag. The sequencer sends the counter a restart strobe on every phase change and sends none while a phase is held. Because of this split, the number of phases does not depend on the clock period. Both interval lengths are parameters, counted in clock cycles. The car sensor must already be synchronous to the clock and is sampled once per cycle.

Top module: `farm_hwy_signal_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the highway lamp shows green and the farm lamp shows red. Reset also clears the interval counter.
- R2: Each lamp output is a 3-bit one-hot code: bit 2 is green, bit 1 is yellow, bit 0 is red. Exactly one bit per road is high in every cycle.
- R3: At least one of the two roads shows red in every cycle.
- R4: During highway green, the phase moves to highway yellow only on a clock edge where `farm_car` is 1 and the long interval has expired. Otherwise highway green holds and the counter is not restarted.
- R5: Highway yellow lasts exactly SHORT_CYCLES+1 cycles and is followed by farm green.
- R6: During farm green, the phase moves to farm yellow on the first clock edge where `farm_car` is 0 or the long interval has expired.
- R7: Farm yellow lasts exactly SHORT_CYCLES+1 cycles and is followed by highway green.
- R8: Every phase change restarts the interval counter. As a result, a highway green entered with `farm_car` held at 1 lasts exactly LONG_CYCLES+1 cycles, and the same holds for a farm green.
- R9: The interval counter stops at LONG_CYCLES and does not wrap. After a long idle highway green, a car seen at a clock edge ends the green at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| farm_car | input | 1 | Farm-road vehicle present (synchronous) |
| hwy_lamp | output | 3 | Highway lamp, one-hot {green, yellow, red} |
| farm_lamp | output | 3 | Farm-road lamp, one-hot {green, yellow, red} |

## Verification
The bench holds the highway idle for much longer than the long interval and then raises the car sensor. A counter that wraps, or that restarts on self-loops, would delay the handover instead of acting at that same edge. With the sensor held high, the bench measures how long each phase lasts. A missing restart on a phase change would shorten the next green, and an off-by-one compare would stretch or cut the yellows. The bench drops the sensor in the middle of a farm green to catch a design that waits for the long interval anyway. A pseudo-random sensor pattern, with a reset applied mid-run, is compared cycle by cycle against a behavioural model to expose wrong priorities between the sensor and the timeout flags.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'd0,
    PH_HWY_WARN = 2'd1,
    PH_FARM_GO  = 2'd2,
    PH_FARM_WARN = 2'd3
  } tl_phase_e;

  localparam int LAMP_W = 3;
  localparam logic [LAMP_W-1:0] LAMP_RED = 3'b001;
  localparam logic [LAMP_W-1:0] LAMP_YEL = 3'b010;
  localparam logic [LAMP_W-1:0] LAMP_GRN = 3'b100;

endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 12,
  localparam int CW = $clog2(LONG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_top;

  assign at_top = (cnt_q == CW'(LONG_CYCLES));

  // Restart always loads; otherwise advance until the ceiling.
  always_comb begin
    cnt_en = restart || !at_top;
    cnt_d  = restart ? '0 : (cnt_q + CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign short_done = (cnt_q >= CW'(SHORT_CYCLES));
  assign long_done  = at_top;

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (long_done && !restart) |=> long_done);

  assert_short_before_long_R9: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |-> short_done);

endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      car_seen,
  input  logic      short_done,
  input  logic      long_done,
  output tl_phase_e phase,
  output logic      restart
);

  tl_phase_e phase_q;
  tl_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_HWY_GO:    if (car_seen && long_done)   phase_d = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done)              phase_d = PH_FARM_GO;
      PH_FARM_GO:   if (!car_seen || long_done)  phase_d = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done)              phase_d = PH_HWY_GO;
      default:                                   phase_d = PH_HWY_GO;
    endcase
  end

  assign restart = (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HWY_GO;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  assert_hwy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HWY_GO && !(car_seen && long_done)) |=> (phase_q == PH_HWY_GO));

  assert_hwy_warn_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HWY_WARN && short_done) |=> (phase_q == PH_FARM_GO));

  assert_farm_go_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FARM_GO && (!car_seen || long_done)) |=> (phase_q == PH_FARM_WARN));

  assert_farm_warn_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FARM_WARN && short_done) |=> (phase_q == PH_HWY_GO));

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
(
  input  tl_phase_e         phase,
  output logic [LAMP_W-1:0] hwy_lamp,
  output logic [LAMP_W-1:0] farm_lamp
);

  always_comb begin
    hwy_lamp  = LAMP_GRN;
    farm_lamp = LAMP_RED;
    unique case (phase)
      PH_HWY_GO:    begin hwy_lamp = LAMP_GRN; farm_lamp = LAMP_RED; end
      PH_HWY_WARN:  begin hwy_lamp = LAMP_YEL; farm_lamp = LAMP_RED; end
      PH_FARM_GO:   begin hwy_lamp = LAMP_RED; farm_lamp = LAMP_GRN; end
      PH_FARM_WARN: begin hwy_lamp = LAMP_RED; farm_lamp = LAMP_YEL; end
      default:      begin hwy_lamp = LAMP_GRN; farm_lamp = LAMP_RED; end
    endcase
  end

endmodule

// File: rtl/farm_hwy_signal_ctrl.sv
module farm_hwy_signal_ctrl
  import tl_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       farm_car,
  output logic [2:0] hwy_lamp,
  output logic [2:0] farm_lamp
);

  if (SHORT_CYCLES < 1 || SHORT_CYCLES >= LONG_CYCLES) begin : g_bad_intervals
    $error("SHORT_CYCLES must be at least 1 and below LONG_CYCLES");
  end

  tl_phase_e phase;
  logic      restart;
  logic      short_done;
  logic      long_done;

  tl_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .car_seen   (farm_car),
    .short_done (short_done),
    .long_done  (long_done),
    .phase      (phase),
    .restart    (restart)
  );

  tl_interval_timer #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .short_done (short_done),
    .long_done  (long_done)
  );

  tl_lamp_decode u_dec (
    .phase     (phase),
    .hwy_lamp  (hwy_lamp),
    .farm_lamp (farm_lamp)
  );

  assert_lamp_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(hwy_lamp) && $onehot(farm_lamp));

  assert_one_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_lamp[0] || farm_lamp[0]);

  assert_restart_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart) |=> $stable(hwy_lamp) && $stable(farm_lamp));

endmodule

// File: tb/farm_hwy_signal_ctrl_tb_top.sv
`timescale 1ns/1ps
module farm_hwy_signal_ctrl_tb_top;

  localparam int SHORT = 3;
  localparam int LONG  = 8;
  localparam logic [2:0] RED = 3'b001, YEL = 3'b010, GRN = 3'b100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic farm_car = 1'b0;
  logic [2:0] hwy_lamp, farm_lamp;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  farm_hwy_signal_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) dut_i (
    .clk(clk), .rst_n(rst_n), .farm_car(farm_car),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp)
  );

  // Behavioural reference: phase 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
  int m_phase = 0;
  int m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      m_cnt = 0;
    end else begin
      int nxt;
      nxt = m_phase;
      if (m_phase == 0 && farm_car && m_cnt >= LONG) nxt = 1;
      else if (m_phase == 1 && m_cnt >= SHORT) nxt = 2;
      else if (m_phase == 2 && (!farm_car || m_cnt >= LONG)) nxt = 3;
      else if (m_phase == 3 && m_cnt >= SHORT) nxt = 0;
      if (nxt != m_phase) m_cnt = 0;
      else if (m_cnt < LONG) m_cnt = m_cnt + 1;
      m_phase = nxt;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Lock-step comparison on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [2:0] eh, ef;
      string tag;
      case (m_phase)
        0: begin eh = GRN; ef = RED; tag = "R4"; end
        1: begin eh = YEL; ef = RED; tag = "R5"; end
        2: begin eh = RED; ef = GRN; tag = "R6"; end
        default: begin eh = RED; ef = YEL; tag = "R7"; end
      endcase
      if (!rst_n) tag = "R1";
      chk(hwy_lamp == eh, {tag, " hwy"}, hwy_lamp, eh);
      chk(farm_lamp == ef, {tag, " farm"}, farm_lamp, ef);
      chk($onehot(hwy_lamp) && $onehot(farm_lamp), "R2 onehot hwy", hwy_lamp, eh);
      chk(hwy_lamp[0] || farm_lamp[0], "R3 red present", farm_lamp, ef);
    end
  end

  // Yellow duration monitor
  int hy_run = 0, fy_run = 0;
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (hwy_lamp == YEL) hy_run++;
      else begin
        if (hy_run != 0) chk_int(hy_run == SHORT + 1, "R5 hwy yellow length", hy_run, SHORT + 1);
        hy_run = 0;
      end
      if (farm_lamp == YEL) fy_run++;
      else begin
        if (fy_run != 0) chk_int(fy_run == SHORT + 1, "R7 farm yellow length", fy_run, SHORT + 1);
        fy_run = 0;
      end
    end else begin
      hy_run = 0;
      fy_run = 0;
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    chk(hwy_lamp == GRN && farm_lamp == RED, "R1 reset lamps", {hwy_lamp}, GRN);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hwy_lamp == GRN && farm_lamp == RED, "R1 after release", hwy_lamp, GRN);
    // R4: no car, long idle highway green
    repeat (30) @(negedge clk);
    chk(hwy_lamp == GRN, "R4 idle hold", hwy_lamp, GRN);
    // R9: saturated counter, car leads to handover at the next edge
    farm_car = 1'b1;
    @(negedge clk);
    chk(hwy_lamp == YEL, "R9 immediate handover", hwy_lamp, YEL);
    // R8: with car held, farm green lasts LONG+1
    n = 0;
    while (farm_lamp != GRN && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (farm_lamp == GRN && n < 100) begin @(negedge clk); n++; end
    chk_int(n == LONG + 1, "R8 farm green length", n, LONG + 1);
    // R8: highway green entered with car held lasts LONG+1
    n = 0;
    while (hwy_lamp != GRN && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (hwy_lamp == GRN && n < 100) begin @(negedge clk); n++; end
    chk_int(n == LONG + 1, "R8 hwy green length", n, LONG + 1);
    // R6: car leaves mid farm green
    n = 0;
    while (farm_lamp != GRN && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    farm_car = 1'b0;
    @(negedge clk);
    chk(farm_lamp == YEL, "R6 early farm exit", farm_lamp, YEL);
    // R4: short car pulses during highway green do not end it early
    n = 0;
    while (hwy_lamp != GRN && n < 100) begin @(negedge clk); n++; end
    repeat (3) begin
      farm_car = 1'b1; @(negedge clk);
      farm_car = 1'b0; @(negedge clk);
    end
    chk(hwy_lamp == GRN, "R4 early car ignored", hwy_lamp, GRN);
    // Pseudo-random sensor traffic with a mid-run reset
    lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      farm_car = lfsr[0] | lfsr[1];
      if (i == 300) rst_n = 1'b0;
      if (i == 303) rst_n = 1'b1;
      @(negedge clk);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule